// File: doc/BRIEF.md
# Ethernet PHY Management Register Set with Link Interrupts

This block holds the management registers of a 10/100 Ethernet transceiver as a host reaches them through a small parallel register port. Each access selects one of 32 register addresses with a 5-bit address. A write stores 16 bits after the register's write mask has been applied. A read returns 16 bits in the clock cycle after the strobe. The block keeps the control, status, advertisement, interrupt-flag and interrupt-mask registers. The other defined registers return fixed values.

A synchronous link-state input drives the link bits of the status register. Every link transition is latched into interrupt flags. The host clears these flags by reading the flag register. Autonegotiation is modelled as instant. Enabling it marks it complete at once, and the link partner's abilities are a fixed value. One level interrupt output is high while any flag is set whose mask bit is also set. A write with the control reset bit set returns every register to its reset value. One cycle later the block applies the present link level again, so the link flags are raised once more.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, control (address 0) reads 0x3000, advertisement (address 4) reads 0x01E1 and the mask (address 30) reads 0x0000. Status (address 1) reads 0x7809 with the link down and 0x782D with the link up.
- R2: A control write without bit 15 stores only bits 14, 13, 12, 11, 8 and 7 (mask 0x7980). Writing bit 12 as 1 sets status bit 5 (autonegotiation complete) in the same edge.
- R3: A control write with bit 15 set ignores the other data bits and returns control, status, advertisement, mask and flags to their reset values. On the next clock edge the current link level is applied again, as in R7 and R8.
- R4: An advertisement write keeps only the bits in mask 0x2D7F and always sets bit 7, so 0xFFFF reads back 0x2DFF and 0x0000 reads back 0x0080.
- R5: The registers at addresses 2 and 3 read the identifier parameters. Address 5 reads 0x0DE1 and address 6 reads 0x0001, whatever is written to them.
- R6: Addresses 17, 18, 27 and 31, every address without a defined register, and writes to the read-only addresses all read 0 and change no state. Address 29 is read-only as well.
- R7: A falling link input clears status bits 2 and 5 and sets flag bit 4.
- R8: A rising link input sets status bits 2 and 5 and sets flag bits 7 and 6.
- R9: A read of address 29 returns the flags in bits 7:0 and clears them at the same edge. A link event in that same cycle leaves its new flags set.
- R10: A write to address 30 stores data bits 7:0. Reads of address 30 return them with bits 15:8 at zero.
- R11: irq is high exactly when some flag bit and its mask bit are both set. It follows every flag or mask change in the cycle after the edge that made it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 5 | Register address of the access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 16 | Read data, valid in the cycle after rd_en |
| link_up | input | 1 | Link level, 1 for up, synchronous to clk |
| irq | output | 1 | Level interrupt to the host |

## Verification
A wrong flag or mask bit appears on irq in the cycle after the edge that stored it. It also shows in the next read of address 29 or 30, one cycle after that read is issued. A status or control bit that is lost or stuck appears in the first read of address 1 or 0 after the event that should have changed it. Any error in the delayed reapply of the link after a soft reset appears as missing or extra flags two cycles after the reset write. The bench triggers a link event in the same cycle as a flag read, so the ordering of clear and set is checked at the read-data port.

// File: rtl/phy_mgmt_pkg.sv
// Shared constants of the PHY management register set.
// Assumes a 5-bit register address and 16-bit registers; field positions
// follow the usual management register layout.
package phy_mgmt_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 5;
    localparam int FLAG_W = 8;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTRL    = 5'd0;
    localparam logic [ADDR_W-1:0] A_STAT    = 5'd1;
    localparam logic [ADDR_W-1:0] A_ID_HI   = 5'd2;
    localparam logic [ADDR_W-1:0] A_ID_LO   = 5'd3;
    localparam logic [ADDR_W-1:0] A_ADV     = 5'd4;
    localparam logic [ADDR_W-1:0] A_PARTNER = 5'd5;
    localparam logic [ADDR_W-1:0] A_EXPAND  = 5'd6;
    localparam logic [ADDR_W-1:0] A_FLAGS   = 5'd29;
    localparam logic [ADDR_W-1:0] A_MASK    = 5'd30;

    // control fields
    localparam int CTL_SOFT_RST = 15;
    localparam int CTL_AN_EN    = 12;
    localparam logic [REG_W-1:0] CTL_WMASK = 16'h7980;
    localparam logic [REG_W-1:0] CTL_RESET = 16'h3000;

    // status fields
    localparam int ST_LINK    = 2;
    localparam int ST_AN_DONE = 5;
    localparam logic [REG_W-1:0] ST_FIXED = 16'h7809;

    // advertisement fields
    localparam logic [REG_W-1:0] ADV_WMASK = 16'h2D7F;
    localparam logic [REG_W-1:0] ADV_FORCE = 16'h0080;
    localparam logic [REG_W-1:0] ADV_RESET = 16'h01E1;

    // fixed registers
    localparam logic [REG_W-1:0] PARTNER_VAL = 16'h0DE1;
    localparam logic [REG_W-1:0] EXPAND_VAL  = 16'h0001;

    // interrupt flag positions
    localparam int FL_ENERGY  = 7;
    localparam int FL_AN_DONE = 6;
    localparam int FL_DOWN    = 4;

    // one-cycle link event pair
    typedef struct packed {
        logic up;
        logic down;
    } link_evt_t;

endpackage

// File: rtl/phy_link_tracker.sv
// Turns the synchronous link level into one-cycle up/down events.
// After any reset (hard or soft) the present level is applied once more
// as an event in the first cycle that reset no longer holds the block.
// Assumes link_up is already synchronous to clk.
module phy_link_tracker
    import phy_mgmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      soft_rst,
    input  logic      link_up,
    output link_evt_t evt,
    output logic      link_prev
);

    logic reapply_q;

    // remember the previous level and whether a reapply is pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_prev <= 1'b0;
            reapply_q <= 1'b1;
        end else begin
            link_prev <= link_up;
            reapply_q <= soft_rst;
        end
    end

    // events: a level change, or the pending reapply; none during soft reset
    always_comb begin
        evt.up   = !soft_rst && link_up  && (reapply_q || !link_prev);
        evt.down = !soft_rst && !link_up && (reapply_q ||  link_prev);
    end

endmodule

// File: rtl/phy_ctrl_block.sv
// Control, status and advertisement registers.
// Applies the write masks, completes autonegotiation on enable and
// mirrors link events into the status link/complete bits.
// Assumes wr_ctrl/wr_adv are one-cycle decoded strobes from the top.
module phy_ctrl_block
    import phy_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wr_ctrl,
    input  logic             wr_adv,
    input  logic [REG_W-1:0] wdata,
    input  link_evt_t        evt,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] status_q,
    output logic [REG_W-1:0] adv_q
);

    logic link_st_q;
    logic an_done_q;

    // control register: masked store, reset value on either reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_q <= CTL_RESET;
        end else if (wr_ctrl) begin
            ctrl_q <= wdata & CTL_WMASK;
        end
    end

    // advertisement register: masked store with the forced bit
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            adv_q <= ADV_RESET;
        end else if (wr_adv) begin
            adv_q <= (wdata & ADV_WMASK) | ADV_FORCE;
        end
    end

    // status dynamic bits: link events, then instant autonegotiation
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            link_st_q <= 1'b0;
            an_done_q <= 1'b0;
        end else begin
            if (evt.up) begin
                link_st_q <= 1'b1;
                an_done_q <= 1'b1;
            end else if (evt.down) begin
                link_st_q <= 1'b0;
                an_done_q <= 1'b0;
            end
            if (wr_ctrl && wdata[CTL_AN_EN]) begin
                an_done_q <= 1'b1;
            end
        end
    end

    // status word: fixed capabilities plus the two dynamic bits
    always_comb begin
        status_q             = ST_FIXED;
        status_q[ST_LINK]    = link_st_q;
        status_q[ST_AN_DONE] = an_done_q;
    end

endmodule

// File: rtl/phy_irq_unit.sv
// Interrupt flags, mask and level interrupt output.
// Flags are set by link events and cleared by a flag-register read;
// a set in the same cycle as the clear wins. irq is a plain AND-OR of
// registered state, so it changes only after a clock edge.
module phy_irq_unit
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  link_evt_t         evt,
    input  logic              flags_rd,
    input  logic              mask_wr,
    input  logic [FLAG_W-1:0] mask_wdata,
    output logic [FLAG_W-1:0] flags_q,
    output logic [FLAG_W-1:0] mask_q,
    output logic              irq
);

    logic [FLAG_W-1:0] set_vec;

    // map link events onto flag positions
    always_comb begin
        set_vec             = '0;
        set_vec[FL_ENERGY]  = evt.up;
        set_vec[FL_AN_DONE] = evt.up;
        set_vec[FL_DOWN]    = evt.down;
    end

    // one sticky flag per bit: set beats read-clear
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                flags_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                flags_q[i] <= 1'b1;
            end else if (flags_rd) begin
                flags_q[i] <= 1'b0;
            end
        end
    end

    // mask register: low bits of the write data
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= mask_wdata;
        end
    end

    // level interrupt from enabled flags
    assign irq = |(flags_q & mask_q);

endmodule

// File: rtl/phy_mgmt_regs.sv
// Top of the PHY management register set.
// Decodes the register port, instantiates the link tracker, the
// control/status block and the interrupt unit, and registers read data.
// Assumes at most one of wr_en/rd_en matters per address per cycle;
// a simultaneous read sees the values before the write.
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter logic [REG_W-1:0] ID_HI = 16'h0A5C,
    parameter logic [REG_W-1:0] ID_LO = 16'h1E31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rd_data,
    input  logic              link_up,
    output logic              irq
);

    localparam int PAD_W = REG_W - FLAG_W;

    logic              soft_rst;
    logic              wr_ctrl;
    logic              wr_adv;
    logic              mask_wr;
    logic              flags_rd;
    logic              link_prev;
    logic              evt_any;
    link_evt_t         evt;
    logic [REG_W-1:0]  ctrl_q;
    logic [REG_W-1:0]  status_q;
    logic [REG_W-1:0]  adv_q;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] mask_q;
    logic [REG_W-1:0]  rd_mux;

    // write and read strobe decode
    always_comb begin
        soft_rst = wr_en && (reg_addr == A_CTRL) && wr_data[CTL_SOFT_RST];
        wr_ctrl  = wr_en && (reg_addr == A_CTRL) && !wr_data[CTL_SOFT_RST];
        wr_adv   = wr_en && (reg_addr == A_ADV);
        mask_wr  = wr_en && (reg_addr == A_MASK);
        flags_rd = rd_en && (reg_addr == A_FLAGS);
        evt_any  = evt.up || evt.down;
    end

    phy_link_tracker u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .link_up   (link_up),
        .evt       (evt),
        .link_prev (link_prev)
    );

    phy_ctrl_block u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_ctrl  (wr_ctrl),
        .wr_adv   (wr_adv),
        .wdata    (wr_data),
        .evt      (evt),
        .ctrl_q   (ctrl_q),
        .status_q (status_q),
        .adv_q    (adv_q)
    );

    phy_irq_unit u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .evt        (evt),
        .flags_rd   (flags_rd),
        .mask_wr    (mask_wr),
        .mask_wdata (wr_data[FLAG_W-1:0]),
        .flags_q    (flags_q),
        .mask_q     (mask_q),
        .irq        (irq)
    );

    // read multiplexer; unknown and unimplemented addresses give zero
    always_comb begin
        case (reg_addr)
            A_CTRL:    rd_mux = ctrl_q;
            A_STAT:    rd_mux = status_q;
            A_ID_HI:   rd_mux = ID_HI;
            A_ID_LO:   rd_mux = ID_LO;
            A_ADV:     rd_mux = adv_q;
            A_PARTNER: rd_mux = PARTNER_VAL;
            A_EXPAND:  rd_mux = EXPAND_VAL;
            A_FLAGS:   rd_mux = {{PAD_W{1'b0}}, flags_q};
            A_MASK:    rd_mux = {{PAD_W{1'b0}}, mask_q};
            default:   rd_mux = '0;
        endcase
    end

    // read data register, loaded on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end

endmodule

// File: rtl/phy_mgmt_chk.sv
// Assertion checker for phy_mgmt_regs, attached with bind.
// Observes ports plus the few internal nets the top exposes.
module phy_mgmt_chk
    import phy_mgmt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [REG_W-1:0]  rd_data,
    input logic              link_up,
    input logic              irq,
    input logic              link_prev,
    input logic              evt_any,
    input logic              soft_rst,
    input logic [REG_W-1:0]  ctrl_q,
    input logic [REG_W-1:0]  status_q,
    input logic [FLAG_W-1:0] flags_q,
    input logic [FLAG_W-1:0] mask_q
);

    // R1
    reset_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_q == CTL_RESET && mask_q == '0));

    // R4
    adv_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == A_ADV) |=> rd_data[7]);

    // R6
    unimpl_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (reg_addr == 5'd17 || reg_addr == 5'd18 ||
                   reg_addr == 5'd27 || reg_addr == 5'd31) && !evt_any)
        |=> ($stable(ctrl_q) && $stable(mask_q) && $stable(flags_q)));

    // R7
    link_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_prev && !link_up && !soft_rst)
        |=> (!status_q[ST_LINK] && flags_q[FL_DOWN]));

    // R8
    link_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_prev && link_up && !soft_rst)
        |=> (status_q[ST_LINK] && status_q[ST_AN_DONE] &&
             flags_q[FL_ENERGY] && flags_q[FL_AN_DONE]));

    // R9
    flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == A_FLAGS && !evt_any) |=> (flags_q == '0 && !irq));

    // R10
    mask_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == A_MASK) |=> (rd_data[REG_W-1:FLAG_W] == '0));

    // R11
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($countones(mask_q) != 0 && $countones(flags_q) != 0));

endmodule

bind phy_mgmt_regs phy_mgmt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .link_up   (link_up),
    .irq       (irq),
    .link_prev (link_prev),
    .evt_any   (evt_any),
    .soft_rst  (soft_rst),
    .ctrl_q    (ctrl_q),
    .status_q  (status_q),
    .flags_q   (flags_q),
    .mask_q    (mask_q)
);

// File: tb/phy_mgmt_regs_bench.sv
// Scoreboard bench: read tasks queue expected words, a monitor pops and
// compares them one cycle after each read strobe.
module phy_mgmt_regs_bench;

    localparam logic [15:0] B_ID_HI = 16'h0A5C;
    localparam logic [15:0] B_ID_LO = 16'h1E31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        link_up = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    phy_mgmt_regs u_phy_mgmt_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .link_up  (link_up),
        .irq      (irq)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // tasks start and end at a falling edge
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_addr = a;
        wr_data  = d;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] e, input string tag);
        reg_addr = a;
        rd_en    = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en    = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        chk(irq === e, tag, {15'd0, irq}, {15'd0, e});
    endtask

    // monitor: compare read data in the cycle after each strobe
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                logic [15:0] e;
                string t;
                @(negedge clk);
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rd_data === e, t, rd_data, e);
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset values, link down reapplied (R3/R7 flag bit 4)
        chk_irq(1'b0, "R1 irq after reset");
        rd(5'd0,  16'h3000, "R1 control");
        rd(5'd1,  16'h7809, "R1 status link down");
        rd(5'd4,  16'h01E1, "R1 advert");
        rd(5'd30, 16'h0000, "R1 mask");
        rd(5'd29, 16'h0010, "R7 reset reapply down flag");
        rd(5'd29, 16'h0000, "R9 flags cleared by read");
        // R5 fixed registers
        rd(5'd2, B_ID_HI, "R5 id hi");
        rd(5'd3, B_ID_LO, "R5 id lo");
        rd(5'd5, 16'h0DE1, "R5 partner");
        rd(5'd6, 16'h0001, "R5 expansion");
        wr(5'd5, 16'h0000);
        wr(5'd6, 16'hFFFF);
        rd(5'd5, 16'h0DE1, "R5 partner after write");
        rd(5'd6, 16'h0001, "R5 expansion after write");
        // R10 mask
        wr(5'd30, 16'hFFFF);
        rd(5'd30, 16'h00FF, "R10 mask low byte");
        // R8 link up
        link_up = 1'b1;
        idle(1);
        chk_irq(1'b1, "R11 irq on link up");
        rd(5'd1,  16'h782D, "R8 status link up");
        rd(5'd29, 16'h00C0, "R8 flags link up");
        chk_irq(1'b0, "R11 irq after clear");
        // R7 link down
        link_up = 1'b0;
        idle(1);
        chk_irq(1'b1, "R11 irq on link down");
        rd(5'd1,  16'h7809, "R7 status link down");
        rd(5'd29, 16'h0010, "R7 flags link down");
        // R6 ignored writes
        wr(5'd17, 16'hFFFF);
        wr(5'd18, 16'hFFFF);
        wr(5'd27, 16'hFFFF);
        wr(5'd31, 16'hFFFF);
        wr(5'd20, 16'hFFFF);
        wr(5'd29, 16'h00FF);
        chk_irq(1'b0, "R6 flag write ignored");
        rd(5'd17, 16'h0000, "R6 reg17");
        rd(5'd18, 16'h0000, "R6 reg18");
        rd(5'd27, 16'h0000, "R6 reg27");
        rd(5'd31, 16'h0000, "R6 reg31");
        rd(5'd20, 16'h0000, "R6 undefined");
        rd(5'd0,  16'h3000, "R6 control untouched");
        rd(5'd30, 16'h00FF, "R6 mask untouched");
        rd(5'd29, 16'h0000, "R6 flags untouched");
        // R2 control masking and instant autonegotiation
        wr(5'd0, 16'h7FFF);
        rd(5'd0, 16'h7980, "R2 control mask");
        rd(5'd1, 16'h7829, "R2 an complete set");
        wr(5'd0, 16'h0000);
        rd(5'd0, 16'h0000, "R2 control cleared");
        // R4 advertisement
        wr(5'd4, 16'hFFFF);
        rd(5'd4, 16'h2DFF, "R4 advert all ones");
        wr(5'd4, 16'h0000);
        rd(5'd4, 16'h0080, "R4 advert forced bit");
        // R9 event in the same cycle as a flag read
        link_up = 1'b1;
        rd(5'd29, 16'h0000, "R9 read sees old flags");
        rd(5'd29, 16'h00C0, "R9 new flags survive");
        // R3 soft reset with link up
        wr(5'd30, 16'h00FF);
        wr(5'd0, 16'hFFFF & ~16'h1000 | 16'h8000);
        idle(1);
        rd(5'd0,  16'h3000, "R3 control reset");
        rd(5'd4,  16'h01E1, "R3 advert reset");
        rd(5'd30, 16'h0000, "R3 mask reset");
        rd(5'd1,  16'h782D, "R3 status link reapplied");
        chk_irq(1'b0, "R11 masked flags give no irq");
        wr(5'd30, 16'h0040);
        chk_irq(1'b1, "R11 irq follows mask");
        wr(5'd30, 16'h0010);
        chk_irq(1'b0, "R11 irq unmatched mask");
        rd(5'd29, 16'h00C0, "R3 flags reapplied");
        idle(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule